// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host run one complete station-management transaction on an MDC/MDIO pair at a time. The host assembles the whole 32-bit management word itself: start pattern, opcode, PHY address, register address, turnaround and data. It writes the word to the frame register, and the block serializes it most-significant bit first. A run of preamble ones always comes before the word. MDC runs at a rate set by a divider register.

For a read word, the block lets go of MDIO from the second turnaround bit onward. It samples the PHY's sixteen data bits and, when the frame ends, places them in the low half of the frame register. Every frame ends by setting an event bit, which software clears by writing a one to it. A busy output covers the whole transaction, and frame writes made during that window are dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The divider field sits at bits 6:1 of register 2 and reads back at those bits, with all other bits zero. Each MDC half period lasts that many system clocks, so MDC = clk / (2 x field). A field of 0 behaves as 1.
- R2: A write to register 0 while idle starts a frame and raises `busy` at the same clock edge. `busy` stays high until the edge that sets the event bit, where it drops.
- R3: MDC idles low. A frame is 32 preamble ones followed by the 32-bit word, MSB (bit 31) first: 64 MDC periods in all. MDIO changes only when MDC falls. When idle, MDIO is released (`mdio_oe` = 0).
- R4: A word whose bits 29:28 equal 2'b10 is a read. For a read, MDIO is released for word bits 16 down to 0. For any other word, MDIO is driven for all 64 bits.
- R5: During a read, word bits 15:0 are sampled from `mdio_i` on MDC rising edges, MSB first. At completion they replace bits 15:0 of register 0, and bits 31:16 keep the written value. With no PHY driving the line, the pull-up makes the result 0xFFFF.
- R6: A frame that is not a read leaves register 0 holding the written word.
- R7: Completion sets bit 23 of register 1. Writing register 1 with bit 23 = 1 clears it, and writing it with bit 23 = 0 has no effect.
- R8: A write to register 0 while `busy` is high is ignored. The frame in flight and the stored word are unchanged.
- R9: If completion and a clearing write to register 1 fall on the same clock edge, the event bit ends set.
- R10: After reset, `mdc`, `mdio_oe` and `busy` are 0, and registers 0, 1 and 2 read as 0. A read strobe returns the selected register on `bus_rdata` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select (0 frame, 1 event, 2 divider) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two things can happen on the same clock edge: the engine setting the event bit at the last MDC fall, and software writing one to clear that bit. The bench counts 128 half periods from the frame-start edge and places the clearing write on exactly the completion edge. It then reads the event register back and expects the bit to still be set. A second clearing write one cycle later must then clear it. A frame write issued mid-transaction is a second overlap, between a host action and a running frame. It is judged from the bits seen on the line and from the stored word.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [1:0] {
    REG_FRAME = 2'd0,
    REG_EVENT = 2'd1,
    REG_DIV   = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  localparam int EVT_BIT       = 23;
  localparam int FRAME_W       = 32;
  localparam int RD_DATA_W     = 16;
  localparam int TA_LAST_POS   = 16;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cyc,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             tick;

  // A zero field would stall the clock; treat it as one.
  always_comb begin
    lim  = (half_cyc == '0) ? DIV_W'(1) : half_cyc;
    tick = run && (cnt >= lim - 1'b1);
    rise = tick && !mdc;
    fall = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [FRAME_W-1:0]   frame_in,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic                 is_read,
  output logic [RD_DATA_W-1:0] rd_data
);
  localparam int TOT    = PRE_LEN + FRAME_W;
  localparam int IDX_W  = $clog2(TOT);
  localparam int FPOS_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOT - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);

  logic [FRAME_W-1:0]   frame_q;
  logic [IDX_W-1:0]     idx;
  logic                 active;
  logic [IDX_W-1:0]     nxt_idx;
  logic [IDX_W-1:0]     nxt_pos;
  logic [IDX_W-1:0]     cur_pos;
  logic                 nxt_in_frame;
  logic                 nxt_o;
  logic                 nxt_oe;
  logic                 last_bit;

  always_comb begin
    nxt_idx      = idx + 1'b1;
    nxt_pos      = LAST_IDX - nxt_idx;
    cur_pos      = LAST_IDX - idx;
    nxt_in_frame = (nxt_idx >= PRE_IDX);
    nxt_o        = nxt_in_frame ? frame_q[nxt_pos[FPOS_W-1:0]] : 1'b1;
    nxt_oe       = !(is_read && nxt_in_frame &&
                     (nxt_pos <= IDX_W'(TA_LAST_POS)));
    last_bit     = (idx == LAST_IDX);
    done         = active && fall && last_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      idx     <= '0;
      active  <= 1'b0;
      is_read <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      frame_q <= frame_in;
      is_read <= (frame_in[FRAME_W-3 -: 2] == OP_READ);
      idx     <= '0;
      active  <= 1'b1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (rise && is_read && (idx >= PRE_IDX) &&
          (cur_pos < IDX_W'(RD_DATA_W))) begin
        rd_data <= {rd_data[RD_DATA_W-2:0], mdio_i};
      end
      if (fall) begin
        if (last_bit) begin
          active  <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= nxt_idx;
          mdio_o  <= nxt_o;
          mdio_oe <= nxt_oe;
        end
      end
    end
  end

  // R3: preamble bits are driven ones
  assert_preamble_driven_R3: assert property (@(posedge clk) disable iff (rst)
    (active && idx < PRE_IDX) |-> (mdio_oe && mdio_o));

  // R4: read frames leave the line free from the second turnaround bit on
  assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
    (active && is_read && idx >= PRE_IDX && cur_pos <= IDX_W'(TA_LAST_POS))
      |-> !mdio_oe);

  // R4: write frames drive every bit
  assert_write_driven_R4: assert property (@(posedge clk) disable iff (rst)
    (active && !is_read) |-> mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [FRAME_W-1:0]   data_q;
  logic                 evt_q;
  logic [DIV_W-1:0]     div_q;
  logic                 accept;
  logic                 evt_clr;
  logic                 rise_s;
  logic                 fall_s;
  logic                 done_s;
  logic                 rd_s;
  logic [RD_DATA_W-1:0] cap_s;

  always_comb begin
    accept  = bus_wr && (bus_addr == REG_FRAME) && !busy;
    evt_clr = bus_wr && (bus_addr == REG_EVENT) && bus_wdata[EVT_BIT];
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst(rst), .run(busy), .half_cyc(div_q),
    .mdc(mdc), .rise(rise_s), .fall(fall_s)
  );

  mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk(clk), .rst(rst), .start(accept), .frame_in(bus_wdata),
    .rise(rise_s), .fall(fall_s), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done_s),
    .is_read(rd_s), .rd_data(cap_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      busy      <= 1'b0;
      evt_q     <= 1'b0;
      div_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (accept) begin
        data_q <= bus_wdata;
        busy   <= 1'b1;
      end else if (done_s) begin
        busy <= 1'b0;
        if (rd_s) data_q[RD_DATA_W-1:0] <= cap_s;
      end
      // completion wins over a simultaneous clear
      if (done_s)       evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
      if (bus_wr && bus_addr == REG_DIV) div_q <= bus_wdata[DIV_W:1];
      if (bus_rd) begin
        case (bus_addr)
          REG_FRAME: bus_rdata <= data_q;
          REG_EVENT: bus_rdata <= 32'(evt_q) << EVT_BIT;
          REG_DIV:   bus_rdata <= 32'(div_q) << 1;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // R2: an accepted frame write makes the block busy and starts driving
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && mdio_oe && mdio_o));

  // R7: completion leaves the event set and the block idle
  assert_done_event_R7: assert property (@(posedge clk) disable iff (rst)
    done_s |=> (evt_q && !busy));

  // R8: frame writes during a transaction do not touch the stored word
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == REG_FRAME && !done_s) |=> $stable(data_q));

  // R9: set beats clear on the same edge
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (done_s && evt_clr) |=> evt_q);

  // R3: quiet line while idle
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy, mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_fail = 0;

  // PHY model state
  logic        phy_read = 1'b0;
  logic        phy_present = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_drv = 1'b0;
  logic        phy_val = 1'b1;
  logic        prev_mdc = 1'b0;
  int          rise_n = 0;
  int          gap = 0;
  int          last_gap = 0;
  logic [63:0] cap_line = '0;
  logic [63:0] cap_oe = '0;

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always @(negedge clk) begin
    gap = gap + 1;
    if (mdc && !prev_mdc) begin
      if (rise_n < 64) begin
        cap_line[63-rise_n] = mdio_i;
        cap_oe[63-rise_n]   = mdio_oe;
      end
      if (rise_n > 0) last_gap = gap;
      gap = 0;
      rise_n = rise_n + 1;
    end
    if (!mdc && prev_mdc) begin
      phy_drv = 1'b0;
      if (phy_read && phy_present && rise_n < 64) begin
        if (63 - rise_n == 16) begin
          phy_drv = 1'b1; phy_val = 1'b0;
        end else if (63 - rise_n <= 15) begin
          phy_drv = 1'b1; phy_val = phy_data[63-rise_n];
        end
      end
    end
    prev_mdc = mdc;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic arm_phy(input logic rd, input logic present, input logic [15:0] d);
    phy_read = rd; phy_present = present; phy_data = d;
    phy_drv = 1'b0; rise_n = 0; gap = 0; last_gap = 0;
    cap_line = '0; cap_oe = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 mdc", 64'(mdc), 64'd0);
    chk("R10 mdio_oe", 64'(mdio_oe), 64'd0);
    chk("R10 busy", 64'(busy), 64'd0);
    bus_read(2'd0, d); chk("R10 frame reg", 64'(d), 64'd0);
    bus_read(2'd1, d); chk("R10 event reg", 64'(d), 64'd0);
    bus_read(2'd2, d); chk("R10 divider reg", 64'(d), 64'd0);
  endtask

  task automatic t_write_frame(input int h, input logic [31:0] f);
    logic [31:0] d;
    bus_write(2'd2, 32'(h) << 1);
    bus_read(2'd2, d);
    chk("R1 divider readback", 64'(d), 64'(32'(h) << 1));
    arm_phy(1'b0, 1'b1, 16'h0);
    bus_write(2'd0, f);
    chk("R2 busy after start", 64'(busy), 64'd1);
    wait_idle();
    chk("R3 serialized bits", cap_line, {32'hFFFF_FFFF, f});
    chk("R3 mdc rises", 64'(rise_n), 64'd64);
    chk("R4 write frame driven", cap_oe, '1);
    chk("R1 mdc period", 64'(last_gap), 64'(2 * ((h == 0) ? 1 : h)));
    chk("R3 idle released", 64'({mdc, mdio_oe}), 64'd0);
    bus_read(2'd0, d); chk("R6 frame reg kept", 64'(d), 64'(f));
    bus_read(2'd1, d); chk("R7 event set", 64'(d), 64'(32'h0080_0000));
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, d); chk("R7 write zero no effect", 64'(d), 64'(32'h0080_0000));
    bus_write(2'd1, 32'h0080_0000);
    bus_read(2'd1, d); chk("R7 W1C clears", 64'(d), 64'd0);
  endtask

  task automatic t_read_frame(input logic present, input logic [15:0] pd,
                              input logic [31:0] f, input logic [31:0] exp);
    logic [31:0] d;
    arm_phy(1'b1, present, pd);
    bus_write(2'd0, f);
    wait_idle();
    chk("R3 read header bits", 64'(cap_line[63:17]), 64'({32'hFFFF_FFFF, f[31:17]}));
    chk("R4 read release", cap_oe, {{47{1'b1}}, 17'b0});
    bus_read(2'd0, d);
    chk(present ? "R5 read data" : "R5 no PHY reads FFFF", 64'(d), 64'(exp));
    bus_write(2'd1, 32'h0080_0000);
  endtask

  task automatic t_busy_ignore(input logic [31:0] f1, input logic [31:0] f2);
    logic [31:0] d;
    arm_phy(1'b0, 1'b1, 16'h0);
    bus_write(2'd0, f1);
    repeat (7) @(negedge clk);
    bus_write(2'd0, f2);
    wait_idle();
    chk("R8 line unaffected", cap_line, {32'hFFFF_FFFF, f1});
    bus_read(2'd0, d); chk("R8 stored word kept", 64'(d), 64'(f1));
    bus_write(2'd1, 32'h0080_0000);
  endtask

  task automatic t_collide(input int h);
    logic [31:0] d;
    arm_phy(1'b0, 1'b1, 16'h0);
    bus_write(2'd0, 32'h5002_0000);
    repeat (128 * h - 2) @(negedge clk);
    chk("R2 busy until completion", 64'(busy), 64'd1);
    bus_write(2'd1, 32'h0080_0000);
    chk("R2 busy dropped", 64'(busy), 64'd0);
    bus_read(2'd1, d); chk("R9 set wins over clear", 64'(d), 64'(32'h0080_0000));
    bus_write(2'd1, 32'h0080_0000);
    bus_read(2'd1, d); chk("R7 later clear", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_frame(3, 32'h528E_A55A);
    t_write_frame(0, 32'h5FFE_0001);
    bus_write(2'd2, 32'd4);
    t_read_frame(1'b1, 16'hBEEF, 32'h608A_1234, 32'h608A_BEEF);
    t_read_frame(1'b0, 16'h0000, 32'h6FFE_0000, 32'h6FFE_FFFF);
    t_busy_ignore(32'h5106_00C3, 32'h6000_0000);
    t_collide(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule